// File: doc/BRIEF.md
# Configurable-Aspect Dual-Port Block RAM

A synchronous memory of 4,608 bits, shared by two independent ports on one clock. The bits form 512 byte slots. Each slot holds 8 data bits and one parity bit. Each port picks its own shape at elaboration through a width parameter.

The two ports see the same physical bits. A word written through a narrow port can be read back through a wide port in the same cycle order, and the reverse also holds.

A port can read and write on every cycle. Read data comes out of an output register. Byte enables choose which lanes a write changes. The array starts all-zero at power-up. A synchronous reset clears only the two read registers.

Top module: `aspect_dpram`

## Requirements
- R1: The legal port widths are 1, 2, 4, 8, 16, 32, 9, 18 and 36. The depth is 4096 divided by the port's data bits, where a 9-bit lane counts as 8 data bits. The address is the base-2 logarithm of the depth in bits.
- R2: Read data for the address presented at one rising edge appears after that edge. It holds until the next edge.
- R3: When a port writes an address, the data it reads from that address in the same cycle is the contents before the write.
- R4: On ports 8 bits wide or wider, bit k of the byte enable gates lane k. A disabled lane keeps its old contents, and an all-zero enable changes nothing.
- R5: On 9, 18 and 36-bit ports, lane k occupies data bits [9k+8:9k]. Bit 9k+8 of that lane is the slot's parity bit, and enable bit k also gates that parity bit.
- R6: On 1, 2 and 4-bit ports, the byte-enable input (1 bit) is ignored. Every write updates the addressed bits.
- R7: Slot index for a wide port is addr*lanes+k, with lane k in the less significant position. A narrow port of width W at address n reaches slot n*W/8, bits starting at (n mod 8/W)*W. The lowest address holds the least significant bits.
- R8: A write from an 8, 16 or 32-bit port leaves the parity bits of its slots unchanged.
- R9: When both ports write the same bit in one cycle, port A's value is stored. Bits written by only one port are all stored.
- R10: Every bit of the array reads as zero before its first write.
- R11: While the synchronous active-high reset `rst` is sampled high, both read registers load zero.
- R12: The two ports act independently in one cycle: two reads, two writes, or one of each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset of the read registers |
| a_addr | input | A_AW | Port A word address |
| a_wdata | input | A_W | Port A write data |
| a_we | input | 1 | Port A write enable |
| a_be | input | A_BE | Port A lane enables |
| a_rdata | output | A_W | Port A registered read data |
| b_addr | input | B_AW | Port B word address |
| b_wdata | input | B_W | Port B write data |
| b_we | input | 1 | Port B write enable |
| b_be | input | B_BE | Port B lane enables |
| b_rdata | output | B_W | Port B registered read data |

## Verification
The bench targets the following corner cases:

- **Narrow port writing inside a slot.** A 4-bit port writes one nibble of a slot whose parity bit is set, and the slot is then read through the 36-bit port. A wrong slot or bit mapping shows up as the nibble in the wrong lane or half, or as a lost parity bit.
- **Collision.** Both ports write the same slot in one cycle. Letting B win leaves B's nibble in the stored byte.
- **Disjoint bits in one slot.** Neighbouring bits of one slot are written through the two ports. A read-modify-write merge would drop one port's bits.
- **Parity through a non-parity port.** A 16-bit port writes slots that carry parity. Clearing the parity shows up when the slot is read at 18 bits.
- **Read timing and reset.** A partial lane enable and an all-zero enable are both applied. Read-during-write is checked for old data, and the read is checked for exactly one cycle of latency. The bench also checks that reset clears a non-zero read register.

// File: rtl/aspect_dpram.sv
module aspect_dpram #(
  parameter int A_W = 36,
  parameter int B_W = 4,
  localparam int A_PAR = (A_W % 9 == 0) ? 1 : 0,
  localparam int B_PAR = (B_W % 9 == 0) ? 1 : 0,
  localparam int A_NAR = (A_W < 8) ? 1 : 0,
  localparam int B_NAR = (B_W < 8) ? 1 : 0,
  localparam int A_LN = A_PAR ? A_W / 9 : (A_NAR ? 1 : A_W / 8),
  localparam int B_LN = B_PAR ? B_W / 9 : (B_NAR ? 1 : B_W / 8),
  localparam int A_DEPTH = A_NAR ? 4096 / A_W : 512 / A_LN,
  localparam int B_DEPTH = B_NAR ? 4096 / B_W : 512 / B_LN,
  localparam int A_AW = $clog2(A_DEPTH),
  localparam int B_AW = $clog2(B_DEPTH),
  localparam int A_BE = A_LN,
  localparam int B_BE = B_LN,
  localparam int A_SH = A_NAR ? $clog2(8 / A_W) : 0,
  localparam int B_SH = B_NAR ? $clog2(8 / B_W) : 0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [A_AW-1:0] a_addr,
  input  logic [A_W-1:0]  a_wdata,
  input  logic            a_we,
  input  logic [A_BE-1:0] a_be,
  output logic [A_W-1:0]  a_rdata,
  input  logic [B_AW-1:0] b_addr,
  input  logic [B_W-1:0]  b_wdata,
  input  logic            b_we,
  input  logic [B_BE-1:0] b_be,
  output logic [B_W-1:0]  b_rdata
);

  logic [8:0] mem [512] = '{default: '0};

  logic [3:0] a_en, b_en;
  logic [8:0] a_idx [4];
  logic [8:0] a_msk [4];
  logic [8:0] a_val [4];
  logic [8:0] b_idx [4];
  logic [8:0] b_msk [4];
  logic [8:0] b_val [4];
  logic [A_W-1:0] a_rd;
  logic [B_W-1:0] b_rd;

  generate
    if (A_NAR != 0) begin : g_a_nar
      logic [3:0] off;
      always_comb begin
        off = 4'(32'(a_addr[A_SH-1:0]) * A_W);
        for (int k = 0; k < 4; k++) begin
          a_idx[k] = '0;
          a_msk[k] = '0;
          a_val[k] = '0;
        end
        a_en = '0;
        // lane enable has no effect on a narrow port
        a_en[0] = a_we | (a_we & a_be[0]);
        a_idx[0] = 9'(a_addr >> A_SH);
        a_msk[0] = 9'(((32'd1 << A_W) - 32'd1) << off);
        a_val[0] = 9'(32'(a_wdata) << off);
        a_rd = A_W'(mem[a_idx[0]] >> off);
      end
    end else begin : g_a_wide
      logic [35:0] wd, rd;
      logic [3:0]  be;
      always_comb begin
        wd = 36'(a_wdata);
        be = 4'(a_be);
        rd = '0;
        for (int k = 0; k < 4; k++) begin
          a_idx[k] = 9'(32'(a_addr) * A_LN + k);
          a_en[k] = a_we && (k < A_LN) && be[k];
          if (A_PAR != 0) begin
            a_msk[k] = 9'h1FF;
            a_val[k] = wd[9*k +: 9];
            rd[9*k +: 9] = mem[a_idx[k]];
          end else begin
            a_msk[k] = 9'h0FF;
            a_val[k] = {1'b0, wd[8*k +: 8]};
            rd[8*k +: 8] = mem[a_idx[k]][7:0];
          end
        end
        a_rd = A_W'(rd);
      end
    end

    if (B_NAR != 0) begin : g_b_nar
      logic [3:0] off;
      always_comb begin
        off = 4'(32'(b_addr[B_SH-1:0]) * B_W);
        for (int k = 0; k < 4; k++) begin
          b_idx[k] = '0;
          b_msk[k] = '0;
          b_val[k] = '0;
        end
        b_en = '0;
        // lane enable has no effect on a narrow port
        b_en[0] = b_we | (b_we & b_be[0]);
        b_idx[0] = 9'(b_addr >> B_SH);
        b_msk[0] = 9'(((32'd1 << B_W) - 32'd1) << off);
        b_val[0] = 9'(32'(b_wdata) << off);
        b_rd = B_W'(mem[b_idx[0]] >> off);
      end
    end else begin : g_b_wide
      logic [35:0] wd, rd;
      logic [3:0]  be;
      always_comb begin
        wd = 36'(b_wdata);
        be = 4'(b_be);
        rd = '0;
        for (int k = 0; k < 4; k++) begin
          b_idx[k] = 9'(32'(b_addr) * B_LN + k);
          b_en[k] = b_we && (k < B_LN) && be[k];
          if (B_PAR != 0) begin
            b_msk[k] = 9'h1FF;
            b_val[k] = wd[9*k +: 9];
            rd[9*k +: 9] = mem[b_idx[k]];
          end else begin
            b_msk[k] = 9'h0FF;
            b_val[k] = {1'b0, wd[8*k +: 8]};
            rd[8*k +: 8] = mem[b_idx[k]][7:0];
          end
        end
        b_rd = B_W'(rd);
      end
    end
  endgenerate

  // port B first so that port A's assignments land last
  always_ff @(posedge clk) begin
    for (int k = 0; k < 4; k++)
      if (b_en[k])
        for (int j = 0; j < 9; j++)
          if (b_msk[k][j]) mem[b_idx[k]][j] <= b_val[k][j];
    for (int k = 0; k < 4; k++)
      if (a_en[k])
        for (int j = 0; j < 9; j++)
          if (a_msk[k][j]) mem[a_idx[k]][j] <= a_val[k][j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      a_rdata <= a_rd;
      b_rdata <= b_rd;
    end
  end

endmodule

// File: rtl/aspect_dpram_chk.sv
module aspect_dpram_chk #(
  parameter int A_W = 36,
  parameter int B_W = 4,
  localparam int A_PAR = (A_W % 9 == 0) ? 1 : 0,
  localparam int B_PAR = (B_W % 9 == 0) ? 1 : 0,
  localparam int A_NAR = (A_W < 8) ? 1 : 0,
  localparam int B_NAR = (B_W < 8) ? 1 : 0,
  localparam int A_LN = A_PAR ? A_W / 9 : (A_NAR ? 1 : A_W / 8),
  localparam int B_LN = B_PAR ? B_W / 9 : (B_NAR ? 1 : B_W / 8),
  localparam int A_AW = $clog2(A_NAR ? 4096 / A_W : 512 / A_LN),
  localparam int B_AW = $clog2(B_NAR ? 4096 / B_W : 512 / B_LN)
) (
  input logic            clk,
  input logic            rst,
  input logic [A_AW-1:0] a_addr,
  input logic [A_W-1:0]  a_wdata,
  input logic            a_we,
  input logic [A_LN-1:0] a_be,
  input logic [A_W-1:0]  a_rdata,
  input logic [B_AW-1:0] b_addr,
  input logic [B_W-1:0]  b_wdata,
  input logic            b_we,
  input logic [B_LN-1:0] b_be,
  input logic [B_W-1:0]  b_rdata
);

  a_r11_rst_clears_a: assert property (@(posedge clk) rst |=> a_rdata == '0);
  a_r11_rst_clears_b: assert property (@(posedge clk) rst |=> b_rdata == '0);

  a_r2_hold_when_idle_a: assert property (@(posedge clk) disable iff (rst)
    ($past(!a_we) && $past(!b_we) && $past(!rst) && $stable(a_addr)) |=> $stable(a_rdata));

  a_r2_hold_when_idle_b: assert property (@(posedge clk) disable iff (rst)
    ($past(!a_we) && $past(!b_we) && $past(!rst) && $stable(b_addr)) |=> $stable(b_rdata));

  a_r12_readback_a: assert property (@(posedge clk) disable iff (rst)
    (a_we && ((&a_be) || (A_NAR != 0)) && !b_we) ##1 $stable(a_addr)
      |=> a_rdata == $past(a_wdata, 2));

  a_r12_readback_b: assert property (@(posedge clk) disable iff (rst)
    (b_we && ((&b_be) || (B_NAR != 0)) && !a_we) ##1 $stable(b_addr)
      |=> b_rdata == $past(b_wdata, 2));

endmodule

bind aspect_dpram aspect_dpram_chk #(.A_W(A_W), .B_W(B_W)) u_chk (.*);

// File: tb/aspect_dpram_tb.sv
module aspect_dpram_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [6:0]  a_addr;  logic [35:0] a_wdata; logic a_we; logic [3:0] a_be; logic [35:0] a_rdata;
  logic [9:0]  b_addr;  logic [3:0]  b_wdata; logic b_we; logic [0:0] b_be; logic [3:0]  b_rdata;

  aspect_dpram #(.A_W(36), .B_W(4)) u_dut (
    .clk(clk), .rst(rst),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_be(a_be), .a_rdata(a_rdata),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_be(b_be), .b_rdata(b_rdata));

  logic [7:0]  c_addr;  logic [17:0] c_wdata; logic c_we; logic [1:0] c_be; logic [17:0] c_rdata;
  logic [7:0]  d_addr;  logic [15:0] d_wdata; logic d_we; logic [1:0] d_be; logic [15:0] d_rdata;

  aspect_dpram #(.A_W(18), .B_W(16)) u_dut2 (
    .clk(clk), .rst(rst),
    .a_addr(c_addr), .a_wdata(c_wdata), .a_we(c_we), .a_be(c_be), .a_rdata(c_rdata),
    .b_addr(d_addr), .b_wdata(d_wdata), .b_we(d_we), .b_be(d_be), .b_rdata(d_rdata));

  typedef struct packed {
    logic        awe; logic [6:0] aad; logic [35:0] awd; logic [3:0] abe;
    logic        bwe; logic [9:0] bad; logic [3:0]  bwd;
    logic [35:0] ea;  logic [3:0] eb;  logic [7:0]  req;
  } vec_t;

  // A slot n = A addr n/4 lane n%4; B addr m = slot m/2, nibble m%2
  localparam vec_t VT [12] = '{
    '{1'b1, 7'd1, {9'h1AB, 9'h0CD, 9'h1EF, 9'h012}, 4'hF, 1'b0, 10'd0,  4'h0, 36'h0, 4'h0, 8'd7},  // R7 R3
    '{1'b0, 7'd1, 36'h0, 4'h0, 1'b0, 10'd8,  4'h0, {9'h1AB, 9'h0CD, 9'h1EF, 9'h012}, 4'h2, 8'd7},  // R7 R5
    '{1'b0, 7'd0, 36'h0, 4'h0, 1'b0, 10'd15, 4'h0, 36'h0, 4'hA, 8'd7},                             // R7
    '{1'b1, 7'd1, {9'h000, 9'h155, 9'h000, 9'h1FF}, 4'h5, 1'b1, 10'd11, 4'h3,
      {9'h1AB, 9'h0CD, 9'h1EF, 9'h012}, 4'hE, 8'd3},                                               // R3 R12 R6
    '{1'b0, 7'd1, 36'h0, 4'h0, 1'b0, 10'd9,  4'h0, {9'h1AB, 9'h155, 9'h13F, 9'h1FF}, 4'hF, 8'd4},  // R4 R5 R6
    '{1'b1, 7'd2, 36'h0A5, 4'hF, 1'b1, 10'd16, 4'hC, 36'h0, 4'h0, 8'd9},                           // R9 R3
    '{1'b0, 7'd2, 36'h0, 4'h0, 1'b0, 10'd17, 4'h0, 36'h0A5, 4'hA, 8'd9},                           // R9
    '{1'b1, 7'd2, {4{9'h1FF}}, 4'h0, 1'b1, 10'd17, 4'h6, 36'h0A5, 4'hA, 8'd4},                     // R4 R3
    '{1'b0, 7'd2, 36'h0, 4'h0, 1'b0, 10'd16, 4'h0, 36'h065, 4'h5, 8'd4},                           // R4 R9
    '{1'b1, 7'd3, {9'h111, 9'h122, 9'h133, 9'h144}, 4'hF, 1'b1, 10'd0, 4'h9, 36'h0, 4'h0, 8'd12},  // R12
    '{1'b0, 7'd0, 36'h0, 4'h0, 1'b0, 10'd24, 4'h0, 36'h009, 4'h4, 8'd12},                          // R12 R7
    '{1'b0, 7'd3, 36'h0, 4'h0, 1'b0, 10'd31, 4'h0, {9'h111, 9'h122, 9'h133, 9'h144}, 4'h1, 8'd7}   // R7 R1
  };

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_all();
    a_we = 0; a_be = '0; a_wdata = '0; b_we = 0; b_be = '0; b_wdata = '0;
    c_we = 0; c_be = '0; c_wdata = '0; d_we = 0; d_be = '0; d_wdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  initial begin
    a_addr = '0; b_addr = '0; c_addr = '0; d_addr = '0;
    idle_all();
    repeat (3) tick();
    chk("R11 reset a", a_rdata, 36'h0);
    chk("R11 reset b", 36'(b_rdata), 36'h0);
    @(negedge clk); rst = 0;
    a_addr = 7'd127; b_addr = 10'd1023;
    tick();
    chk("R10 zero top a", a_rdata, 36'h0);
    chk("R10 zero top b", 36'(b_rdata), 36'h0);

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      a_we = VT[i].awe; a_addr = VT[i].aad; a_wdata = VT[i].awd; a_be = VT[i].abe;
      b_we = VT[i].bwe; b_addr = VT[i].bad; b_wdata = VT[i].bwd; b_be = 1'b0;
      tick();
      chk($sformatf("R%0d vec%0d a", VT[i].req, i), a_rdata, VT[i].ea);
      chk($sformatf("R%0d vec%0d b", VT[i].req, i), 36'(b_rdata), 36'(VT[i].eb));
    end

    // R2 latency: new address does not show before the edge
    @(negedge clk); idle_all(); a_addr = 7'd1; tick();
    @(negedge clk); a_addr = 7'd3; #1;
    chk("R2 before edge", a_rdata, {9'h1AB, 9'h155, 9'h13F, 9'h1FF});
    tick();
    chk("R2 after edge", a_rdata, {9'h111, 9'h122, 9'h133, 9'h144});
    @(negedge clk); rst = 1; tick();
    chk("R11 reset clears data", a_rdata, 36'h0);
    @(negedge clk); rst = 0;

    // second instance: 18-bit parity port A, 16-bit plain port B
    @(negedge clk); c_we = 1; c_addr = 8'd5; c_wdata = {9'h1AA, 9'h155}; c_be = 2'b11; tick();
    @(negedge clk); c_we = 0; d_we = 1; d_addr = 8'd5; d_wdata = 16'h1234; d_be = 2'b11; tick();
    @(negedge clk); d_we = 0; tick();
    chk("R8 parity kept", 36'(c_rdata), 36'({9'h112, 9'h134}));
    chk("R7 16-bit read", 36'(d_rdata), 36'h1234);
    @(negedge clk); d_we = 1; d_wdata = 16'hFFFF; d_be = 2'b01; tick();
    @(negedge clk); d_we = 0; tick();
    chk("R4 lane0 only via 18", 36'(c_rdata), 36'({9'h112, 9'h1FF}));
    chk("R4 lane0 only via 16", 36'(d_rdata), 36'h12FF);
    @(negedge clk);
    c_we = 1; c_addr = 8'd6; c_wdata = {9'h0AA, 9'h0BB}; c_be = 2'b11;
    d_we = 1; d_addr = 8'd6; d_wdata = 16'hCCCC; d_be = 2'b11; tick();
    @(negedge clk); c_we = 0; d_we = 0; tick();
    chk("R9 A wins 18", 36'(c_rdata), 36'({9'h0AA, 9'h0BB}));
    chk("R9 A wins 16", 36'(d_rdata), 36'hAABB);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule